// File: doc/BRIEF.md
# Transmit Status Register Unit

This unit keeps the per-frame transmit status for a simple 10 Mb/s Ethernet MAC. A transmit engine sends it event pulses: frame start, frame end, collision, underrun and byte-time ticks while deferring. It also sends the current link-integrity level. From these the unit keeps a 16-bit live status word and four saturating 4-bit event counters. It also owns the transmit-enable control that gates the start of new frames.

When a frame ends, the unit presents that frame's status word with a one-cycle strobe, so that it can be stored as the first word of the packet's buffer. It then clears the per-frame bits for the next frame. Clearing transmit enable stops the transmitter only at the next frame boundary. An underrun forces transmit enable off at once. A change of link state raises an interrupt pulse when the interrupt is enabled. The counters are read through a port that returns all four counters together and clears them on the read.

Top module: `tx_status_unit`

## Requirements
- R1: A cycle with `ctl_wr`=1 loads `ctl_tx_en` into `tx_enable`, visible on the next cycle. `ev_frame_start` starts a frame (`tx_busy` goes 1 on the next cycle) only when `tx_enable`=1 and `tx_busy`=0. Otherwise it is ignored.
- R2: Clearing `tx_enable` while a frame is in progress does not end it. `tx_busy` stays 1 until `ev_frame_end`, and that frame still produces its snapshot.
- R3: `ev_underrun` sets status bit 5 (underrun) and clears `tx_enable` on the next cycle. It takes priority over a write to `ctl_wr` in the same cycle.
- R4: Status bit 5 stays set until a cycle with `ctl_wr`=1 and `ctl_tx_en`=1 and no underrun. A write of 0 leaves it set.
- R5: A change of `link_ok_in` in either direction gives a one-cycle `link_irq` pulse on the next cycle, but only if `link_irq_en`=1 in the cycle of the change. Status bit 7 follows `link_ok_in` with one cycle of delay.
- R6: At each frame end, each counter whose per-frame flag is set is incremented. The counters hold at 15 and do not wrap. Status bit 6 (rollover) is set when any counter steps from 14 to 15.
- R7: A cycle with `cnt_rd`=1 clears all four counters and the rollover bit on the next cycle. This takes priority over an increment in the same cycle.
- R8: While `tx_busy`=1 and `defer_active`=1, each `byte_tick` counts one byte time, and status bit 3 (deferred) is set. Status bit 4 (excessive deferral) is set once more than 3036 byte times have been counted in the frame. The byte-time count restarts at each frame start, and bits 3 and 4 are cleared after each frame end.
- R9: One cycle after an `ev_frame_end` that ends a frame, `snap_valid` is 1 for one cycle. `snap_word` then holds the status word as it stood in the end cycle, with bit 0 set to 1 if no underrun occurred during the frame and 0 otherwise. Live bit 0 takes that same value.
- R10: Bit 9 of the status word is reserved and always reads 0, as do bits 15:10. Bit 8 shows `tx_enable`.
- R11: The first collision of a frame sets status bit 1 (single). A later collision in the same frame clears bit 1 and sets bit 2 (multiple). The two bits are never both set.
- R12: `cnt_data` holds the counters in fixed nibbles: [3:0] single-collision frames, [7:4] multiple-collision frames, [11:8] deferred frames, [15:12] excessive-deferral frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for transmit enable |
| ctl_tx_en | input | 1 | Value written to transmit enable |
| link_irq_en | input | 1 | Enables the link-change interrupt |
| ev_underrun | input | 1 | Transmit underrun pulse |
| ev_frame_start | input | 1 | Frame start request pulse |
| ev_frame_end | input | 1 | Frame end pulse |
| ev_collision | input | 1 | Collision pulse |
| defer_active | input | 1 | Transmit is currently deferring |
| byte_tick | input | 1 | One byte time elapsed |
| link_ok_in | input | 1 | Link-integrity state |
| cnt_rd | input | 1 | Counter read strobe, clears the counters |
| tx_enable | output | 1 | Current transmit enable |
| tx_busy | output | 1 | A frame is in progress |
| status_word | output | 16 | Live status word |
| snap_valid | output | 1 | Frame-end snapshot strobe |
| snap_word | output | 16 | Status snapshot of the finished frame |
| link_irq | output | 1 | Link-change interrupt pulse |
| cnt_data | output | 16 | Packed counter values |

## Verification
The bench checks the deferral limit from both sides: 3036 ticks must leave bit 4 clear and 3037 ticks must set it. An off-by-one compare would flag frames too early or too late. It drives sixteen single-collision frames to show that the counter holds at 15 with rollover set, where a wrapping counter would read 0. It disables transmit in the middle of a frame and then issues a start, where an abrupt stop would lose the snapshot and a missing gate would start a new frame. It also checks that a write of 0 leaves the underrun bit set, that an underrun overrides a simultaneous enable write, and that a link toggle with the interrupt disabled stays silent.

// File: rtl/tx_status_unit.sv
module tx_status_unit #(
  parameter int MAX_FRAME = 1518,
  parameter int CNT_W     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_tx_en,
  input  logic        link_irq_en,
  input  logic        ev_underrun,
  input  logic        ev_frame_start,
  input  logic        ev_frame_end,
  input  logic        ev_collision,
  input  logic        defer_active,
  input  logic        byte_tick,
  input  logic        link_ok_in,
  input  logic        cnt_rd,
  output logic        tx_enable,
  output logic        tx_busy,
  output logic [15:0] status_word,
  output logic        snap_valid,
  output logic [15:0] snap_word,
  output logic        link_irq,
  output logic [15:0] cnt_data
);
  localparam int DEFER_LIMIT = 2 * MAX_FRAME;
  localparam int BW = $clog2(DEFER_LIMIT + 2);
  localparam int NCNT = 4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  logic en_q, busy_q, under_q, uf_q, ok_q, link_q, irq_q, roll_q;
  logic single_q, multi_q, col_seen_q, defd_q, exc_q;
  logic [BW-1:0] bytes_q;
  logic [CNT_W-1:0] cnt_q [NCNT];
  logic snap_v_q;
  logic [15:0] snap_q;
  logic [NCNT-1:0] flags;

  wire start_ok = ev_frame_start && en_q && !busy_q;
  wire end_ok   = ev_frame_end && busy_q;
  wire defer_ev = busy_q && defer_active && byte_tick;

  assign flags = {exc_q, defd_q, multi_q, single_q};
  assign status_word = {7'b0, en_q, link_q, roll_q, under_q, exc_q, defd_q,
                        multi_q, single_q, ok_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; under_q <= 1'b0; uf_q <= 1'b0; busy_q <= 1'b0;
      ok_q <= 1'b0; link_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      link_q <= link_ok_in;
      irq_q  <= link_irq_en && (link_ok_in != link_q);
      if (ev_underrun)  en_q <= 1'b0;
      else if (ctl_wr)  en_q <= ctl_tx_en;
      if (ev_underrun)                under_q <= 1'b1;
      else if (ctl_wr && ctl_tx_en)   under_q <= 1'b0;
      if (ev_underrun)    uf_q <= 1'b1;
      else if (start_ok)  uf_q <= 1'b0;
      if (start_ok)       busy_q <= 1'b1;
      else if (end_ok)    busy_q <= 1'b0;
      if (end_ok)         ok_q <= !uf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start_ok || end_ok) begin
      single_q <= 1'b0; multi_q <= 1'b0; col_seen_q <= 1'b0;
      defd_q <= 1'b0; exc_q <= 1'b0; bytes_q <= '0;
    end else begin
      if (ev_collision && busy_q) begin
        col_seen_q <= 1'b1;
        if (!col_seen_q) single_q <= 1'b1;
        else begin
          single_q <= 1'b0;
          multi_q  <= 1'b1;
        end
      end
      if (defer_ev) begin
        defd_q <= 1'b1;
        if (bytes_q != BMAX) bytes_q <= bytes_q + 1'b1;
        if (bytes_q >= BW'(DEFER_LIMIT)) exc_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_rd) begin
      roll_q <= 1'b0;
      for (int i = 0; i < NCNT; i++) cnt_q[i] <= '0;
    end else if (end_ok) begin
      for (int i = 0; i < NCNT; i++)
        if (flags[i] && cnt_q[i] != CMAX) begin
          cnt_q[i] <= cnt_q[i] + 1'b1;
          if (cnt_q[i] == CMAX - 1'b1) roll_q <= 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_v_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      snap_v_q <= end_ok;
      if (end_ok) snap_q <= {status_word[15:1], !uf_q};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCNT; g++) begin : g_pack
      assign cnt_data[g*4 +: 4] = 4'(cnt_q[g]);
    end
  endgenerate

  assign tx_enable  = en_q;
  assign tx_busy    = busy_q;
  assign snap_valid = snap_v_q;
  assign snap_word  = snap_q;
  assign link_irq   = irq_q;
endmodule

module tx_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        ctl_tx_en,
  input logic        link_irq_en,
  input logic        ev_underrun,
  input logic        ev_frame_end,
  input logic        cnt_rd,
  input logic        tx_enable,
  input logic        tx_busy,
  input logic [15:0] status_word,
  input logic        snap_valid,
  input logic [15:0] snap_word,
  input logic        link_irq,
  input logic [15:0] cnt_data
);
  AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !tx_busy) |=> !tx_busy); // R1
  AST_FRAME_RUNS_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !ev_frame_end) |=> tx_busy); // R2
  AST_UNDERRUN_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> (!tx_enable && status_word[5])); // R3
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[5] && !(ctl_wr && ctl_tx_en)) |=> status_word[5]); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !link_irq_en |=> !link_irq); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> (cnt_data == 16'h0 && !status_word[6])); // R7
  AST_SNAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> $past(ev_frame_end)); // R9
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15:9] == 7'h0); // R10
  AST_COL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[1] && status_word[2]) && !(snap_valid && snap_word[1] && snap_word[2])); // R11
endmodule

bind tx_status_unit tx_status_unit_chk u_chk (.*);

// File: tb/tx_status_unit_bench.sv
module tx_status_unit_bench;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_tx_en = 0, link_irq_en = 0, ev_underrun = 0;
  logic ev_frame_start = 0, ev_frame_end = 0, ev_collision = 0;
  logic defer_active = 0, byte_tick = 0, link_ok_in = 0, cnt_rd = 0;
  logic tx_enable, tx_busy, snap_valid, link_irq;
  logic [15:0] status_word, snap_word, cnt_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tx_status_unit u_tx_status_unit (.*);

  int m_en, m_under, m_uf, m_busy, m_ok, m_single, m_multi, m_ncol;
  int m_defd, m_exc, m_bytes, m_roll, m_link, m_irq, m_snapv, m_snap;
  int m_cnt [4];

  function automatic int mword();
    return m_ok | (m_single << 1) | (m_multi << 2) | (m_defd << 3) | (m_exc << 4)
         | (m_under << 5) | (m_roll << 6) | (m_link << 7) | (m_en << 8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_under = 0; m_uf = 0; m_busy = 0; m_ok = 0; m_single = 0;
      m_multi = 0; m_ncol = 0; m_defd = 0; m_exc = 0; m_bytes = 0; m_roll = 0;
      m_link = 0; m_irq = 0; m_snapv = 0; m_snap = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      int st, fe;
      int fl [4];
      st = (ev_frame_start && m_en && !m_busy) ? 1 : 0;
      fe = (ev_frame_end && m_busy) ? 1 : 0;
      m_snapv = fe;
      if (fe != 0) m_snap = (mword() & 'hFFFE) | (m_uf != 0 ? 0 : 1);
      m_irq = (link_irq_en && (int'(link_ok_in) != m_link)) ? 1 : 0;
      m_link = int'(link_ok_in);
      fl[0] = m_single; fl[1] = m_multi; fl[2] = m_defd; fl[3] = m_exc;
      if (cnt_rd) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_roll = 0;
      end else if (fe != 0) begin
        foreach (m_cnt[i])
          if (fl[i] != 0 && m_cnt[i] < 15) begin
            m_cnt[i]++;
            if (m_cnt[i] == 15) m_roll = 1;
          end
      end
      if (fe != 0) m_ok = (m_uf != 0) ? 0 : 1;
      if (st != 0 || fe != 0) begin
        m_single = 0; m_multi = 0; m_ncol = 0; m_defd = 0; m_exc = 0; m_bytes = 0;
      end else begin
        if (ev_collision && m_busy != 0) begin
          m_ncol++;
          if (m_ncol == 1) m_single = 1;
          else begin m_single = 0; m_multi = 1; end
        end
        if (defer_active && byte_tick && m_busy != 0) begin
          m_defd = 1;
          m_bytes++;
          if (m_bytes > 3036) m_exc = 1;
        end
      end
      if (ev_underrun) m_uf = 1; else if (st != 0) m_uf = 0;
      if (st != 0) m_busy = 1; else if (fe != 0) m_busy = 0;
      if (ev_underrun) begin m_en = 0; m_under = 1; end
      else if (ctl_wr) begin
        m_en = int'(ctl_tx_en);
        if (ctl_tx_en) m_under = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R1 tx_enable", int'(tx_enable), m_en);
    check("R2 tx_busy", int'(tx_busy), m_busy);
    check("R3 underrun bit", int'(status_word[5]), m_under);
    check("R8 deferral bits", int'(status_word[4:3]), (m_exc << 1) | m_defd);
    check("R6 rollover bit", int'(status_word[6]), m_roll);
    check("R10 reserved bits", int'(status_word[15:9]), 0);
    check("R9 status word", int'(status_word), mword());
    check("R9 snap_valid", int'(snap_valid), m_snapv);
    if (m_snapv != 0) check("R9 snap_word", int'(snap_word), m_snap);
    check("R5 link_irq", int'(link_irq), m_irq);
    check("R12 cnt_data", int'(cnt_data),
          m_cnt[0] | (m_cnt[1] << 4) | (m_cnt[2] << 8) | (m_cnt[3] << 12));
  endtask

  always @(negedge clk) if (rst_n && !done) compare();

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(bit v);
    ctl_wr = 1; ctl_tx_en = v; step(); ctl_wr = 0;
  endtask

  task automatic pulse_start(); ev_frame_start = 1; step(); ev_frame_start = 0; endtask
  task automatic pulse_end();   ev_frame_end = 1; step(); ev_frame_end = 0; step(); endtask
  task automatic collide(int n);
    repeat (n) begin ev_collision = 1; step(); ev_collision = 0; end
  endtask

  task automatic defer_frame(int ticks);
    pulse_start();
    defer_active = 1; byte_tick = 1; step(ticks); byte_tick = 0; defer_active = 0;
    step();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    check("R10 reset status", int'(status_word), 0);
    check("R1 reset enable", int'(tx_enable), 0);
    pulse_start(); step();
    check("R1 start ignored when disabled", int'(tx_busy), 0);
    wr_en(1);
    check("R1 enable set", int'(tx_enable), 1);
    pulse_start(); step(2);
    check("R1 frame started", int'(tx_busy), 1);
    ev_frame_end = 1; step(); ev_frame_end = 0;
    check("R9 snap strobe clean frame", int'(snap_valid), 1);
    check("R9 snap ok bit", int'(snap_word[0]), 1);
    step();
    pulse_start(); collide(1); step();
    check("R11 single collision", int'(status_word[2:1]), 1);
    pulse_end();
    pulse_start(); collide(3); step();
    check("R11 multiple collision", int'(status_word[2:1]), 2);
    pulse_end();
    check("R12 nibble layout", int'(cnt_data), 'h0011);
    pulse_start(); step(2);
    wr_en(0);
    step(3);
    check("R2 frame continues after disable", int'(tx_busy), 1);
    ev_frame_end = 1; step(); ev_frame_end = 0;
    check("R2 snapshot after graceful stop", int'(snap_valid), 1);
    pulse_start(); step();
    check("R2 no new frame after stop", int'(tx_busy), 0);
    wr_en(1);
    pulse_start(); step();
    ev_underrun = 1; step(); ev_underrun = 0;
    check("R3 underrun disables", int'(tx_enable), 0);
    check("R3 underrun bit", int'(status_word[5]), 1);
    ev_frame_end = 1; step(); ev_frame_end = 0;
    check("R9 snap ok bit after underrun", int'(snap_word[0]), 0);
    wr_en(0);
    check("R4 write 0 keeps underrun", int'(status_word[5]), 1);
    ctl_wr = 1; ctl_tx_en = 1; ev_underrun = 1; step(); ctl_wr = 0; ev_underrun = 0;
    check("R3 underrun beats write", int'(tx_enable), 0);
    wr_en(1);
    check("R4 write 1 clears underrun", int'(status_word[5]), 0);
    cnt_rd = 1; step(); cnt_rd = 0;
    defer_frame(3036);
    check("R8 3036 byte times not excessive", int'(status_word[4:3]), 1);
    pulse_end();
    defer_frame(3037);
    check("R8 3037 byte times excessive", int'(status_word[4:3]), 3);
    pulse_end();
    check("R8 cleared after frame end", int'(status_word[4:3]), 0);
    check("R12 deferral nibbles", int'(cnt_data), 'h1200);
    for (int k = 0; k < 16; k++) begin
      pulse_start(); collide(1); pulse_end();
    end
    check("R6 saturate at 15", int'(cnt_data[3:0]), 15);
    check("R6 rollover set", int'(status_word[6]), 1);
    cnt_rd = 1; step(); cnt_rd = 0;
    check("R7 read clears counters", int'(cnt_data), 0);
    check("R7 read clears rollover", int'(status_word[6]), 0);
    link_ok_in = 1; step(2);
    check("R5 no irq when disabled", int'(link_irq), 0);
    link_irq_en = 1; link_ok_in = 0; step();
    check("R5 irq on falling link", int'(link_irq), 1);
    step();
    link_ok_in = 1; step();
    check("R5 irq on rising link", int'(link_irq), 1);
    step();
    check("R5 irq is one pulse", int'(link_irq), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule